// File: doc/BRIEF.md
# Multi-Source Event Rate Supervisor

This block watches several independent event sources, such as interrupt request lines, and confirms that each one fires a plausible number of times within an observation window. The window timing is generated outside the block and arrives as a single-cycle window-end strobe. A typical use is confirming that each of several timer interrupts fires about five times in every ten-second window.

Each source has its own down-counter, which is loaded with a per-source preset. Every event pulse on a source lowers that source's counter by one. When the strobe arrives, each remaining count is compared with the source's lower and upper limits. A count outside those limits sets a sticky error flag for that source. All counters are then reloaded from their presets. A combined error output summarises all per-source flags. The flags stay set until an explicit clear input is asserted.

Top module: `event_rate_supervisor`

## Requirements
- R1: While rst_n is low at a clock edge, every error flag is cleared and every counter is loaded with its preset. A strobe given right after reset therefore judges the unmodified preset value.
- R2: A high event bit for a source in a cycle without the strobe lowers that source's counter by exactly one. The counters of the other sources are not affected.
- R3: A counter at zero stays at zero when further events arrive. It never wraps to the maximum value.
- R4: Error flags can only become set on the clock edge at which the window-end strobe is high. Events alone never set a flag.
- R5: At the strobe, a source's flag is set when its remaining count is below its lower limit or above its upper limit. Both limits are inclusive, so a count equal to either limit passes. With preset 10, lower limit 3 and upper limit 7, between 3 and 7 events pass.
- R6: At the strobe edge, every counter is reloaded from the preset value present at that edge. The next window therefore starts from the preset again.
- R7: An event in the same cycle as the strobe is excluded from the window being checked. It is counted into the new window, which therefore starts at preset minus one (or at zero if the preset is zero).
- R8: A set flag stays set until err_clr_i is high at a clock edge. If a new violation is detected at that same edge, setting wins over clearing.
- R9: any_err_o is high exactly when at least one per-source flag is high.
- R10: The flags reflect a window's verdict from the clock edge at which the strobe is sampled. They are visible in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NSRC | One event pulse bit per source |
| win_end_i | input | 1 | Window-end strobe, one cycle wide |
| preset_i | input | NSRC*CW | Per-source reload value; source s occupies bits [s*CW +: CW] |
| lim_lo_i | input | NSRC*CW | Per-source inclusive lower limit, packed the same way |
| lim_hi_i | input | NSRC*CW | Per-source inclusive upper limit, packed the same way |
| err_clr_i | input | 1 | Clears all sticky error flags |
| src_err_o | output | NSRC | Sticky per-source error flags |
| any_err_o | output | 1 | OR of all per-source flags |

## Verification
The counters are not visible at the ports, so saturation and the handling of a coincident event can only be seen indirectly, through the pass/fail verdict of a later window. The stimulus reaches them by choosing limits at which the wrong behaviour falls outside the limits while the correct behaviour stays inside. Examples are a lower limit of zero with more events than the preset, where a wrapped counter would exceed the upper limit. Another is a strobe carrying events followed by a window whose event count lands exactly on a limit only when the extra decrement has been applied. A sweep varies the event count per source across and beyond the preset, so that both limits are crossed on each source with different counts in the same window.

// File: rtl/erss_pkg.sv
// Package: shared default sizing for the event rate supervisor.
// Assumes: counters are unsigned and no wider than 16 bits in practice.
package erss_pkg;
    parameter int unsigned ERSS_DEF_SRCS  = 4;
    parameter int unsigned ERSS_DEF_CNT_W = 8;
endpackage

// File: rtl/erss_counter.sv
// Module: per-source event down-counter.
// Loads the preset on reset and at each window end, and lowers the count
// by one per event, saturating at zero.
// Assumes: win_i is a single-cycle strobe; an event arriving with the
// strobe belongs to the new window.
module erss_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          win_i,
    input  logic [CW-1:0] preset_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;
    logic          at_zero;
    logic          preset_zero;

    assign at_zero     = (cnt_q == '0);
    assign preset_zero = (preset_i == '0);
    assign cnt_o       = cnt_q;

    // Purpose: reload at reset and window end, otherwise count events down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= preset_i;
        end else if (win_i) begin
            cnt_q <= (evt_i && !preset_zero) ? preset_i - 1'b1 : preset_i;
        end else if (evt_i && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: one event lowers the count by one
    p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && evt_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R2: no event, no strobe, no change
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && !evt_i) |=> $stable(cnt_q));
    // R3: zero is sticky between strobes
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && cnt_q == '0) |=> (cnt_q == '0));
    // R6: after a strobe the count is never above the preset that was loaded
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_i |=> (cnt_q <= $past(preset_i)));
endmodule

// File: rtl/erss_flag.sv
// Module: inclusive two-sided limit check with a sticky error flag.
// The flag is set only at a window-end strobe when the count lies outside
// [lo, hi]. It is cleared by clr_i, and a new violation wins over the clear.
// Assumes: cnt_i is the count of the window that is ending.
module erss_flag #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_i,
    input  logic          clr_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    output logic          err_o
);
    logic err_q;
    logic out_of_range;

    assign out_of_range = (cnt_i < lo_i) || (cnt_i > hi_i);
    assign err_o        = err_q;

    // Purpose: sticky flag, set at a failing window end, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (win_i && out_of_range) begin
            err_q <= 1'b1;
        end else if (clr_i) begin
            err_q <= 1'b0;
        end
    end

    // R4: a flag rises only after a strobe
    p_set_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(win_i));
    // R5: a failing count at the strobe raises the flag
    p_violation_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i && (cnt_i < lo_i || cnt_i > hi_i)) |=> err_q);
    // R8: flag holds without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i) |=> err_q);
    // R8: a clear without a strobe drops the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !win_i) |=> !err_q);
endmodule

// File: rtl/event_rate_supervisor.sv
// Module: top of the multi-source event rate supervisor.
// One counter and one limit-checking flag per source; the combined error
// is the OR of all flags.
// Assumes: the window strobe is produced externally and is one cycle wide;
// the preset and limit buses are packed with source s at [s*CW +: CW].
module event_rate_supervisor #(
    parameter int unsigned NSRC = erss_pkg::ERSS_DEF_SRCS,
    parameter int unsigned CW   = erss_pkg::ERSS_DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    evt_i,
    input  logic               win_end_i,
    input  logic [NSRC*CW-1:0] preset_i,
    input  logic [NSRC*CW-1:0] lim_lo_i,
    input  logic [NSRC*CW-1:0] lim_hi_i,
    input  logic               err_clr_i,
    output logic [NSRC-1:0]    src_err_o,
    output logic               any_err_o
);
    localparam int unsigned BUS_W = NSRC * CW;

    logic [BUS_W-1:0] cnt_bus;

    // Purpose: one counter/flag pair per supervised source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        erss_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[s]),
            .win_i    (win_end_i),
            .preset_i (preset_i[s*CW +: CW]),
            .cnt_o    (cnt_bus[s*CW +: CW])
        );
        erss_flag #(.CW(CW)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .win_i (win_end_i),
            .clr_i (err_clr_i),
            .cnt_i (cnt_bus[s*CW +: CW]),
            .lo_i  (lim_lo_i[s*CW +: CW]),
            .hi_i  (lim_hi_i[s*CW +: CW]),
            .err_o (src_err_o[s])
        );
    end

    // Purpose: combined error summary.
    assign any_err_o = |src_err_o;

    // R9: the summary changes only together with some per-source flag
    p_summary_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_err_o) |-> (src_err_o != '0));
endmodule

// File: tb/event_rate_supervisor_tb_top.sv
`timescale 1ns/1ps
module event_rate_supervisor_tb_top;
    localparam int N  = 4;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    evt;
    logic            win;
    logic            clr;
    logic [N*CW-1:0] pre_v, lo_v, hi_v;
    logic [N-1:0]    src_err;
    logic            any_err;

    int pre [N];
    int lo  [N];
    int hi  [N];
    int mcnt[N];
    bit merr[N];
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int s = 0; s < N; s++) begin
            pre_v[s*CW +: CW] = pre[s][CW-1:0];
            lo_v [s*CW +: CW] = lo[s][CW-1:0];
            hi_v [s*CW +: CW] = hi[s][CW-1:0];
        end
    end

    event_rate_supervisor #(.NSRC(N), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .win_end_i(win),
        .preset_i(pre_v), .lim_lo_i(lo_v), .lim_hi_i(hi_v),
        .err_clr_i(clr), .src_err_o(src_err), .any_err_o(any_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, then compare at the next falling edge.
    task automatic step(input logic [N-1:0] ev, input logic w, input logic c, input string tag);
        bit anym;
        evt = ev; win = w; clr = c;
        for (int s = 0; s < N; s++) begin
            bit setv;
            setv = w && (mcnt[s] < lo[s] || mcnt[s] > hi[s]);
            if (setv) merr[s] = 1'b1;
            else if (c) merr[s] = 1'b0;
            if (w) mcnt[s] = (ev[s] && pre[s] != 0) ? pre[s] - 1 : pre[s];
            else if (ev[s] && mcnt[s] > 0) mcnt[s] = mcnt[s] - 1;
        end
        @(negedge clk);
        anym = 1'b0;
        for (int s = 0; s < N; s++) begin
            check(src_err[s] == merr[s], $sformatf("%s src%0d", tag, s), src_err[s], merr[s]);
            anym |= merr[s];
        end
        check(any_err == anym, "R9 combined", any_err, anym);
    endtask

    // One window: counts[s] events on source s, then the strobe.
    task automatic window(input int c0, input int c1, input int c2, input int c3,
                          input logic [N-1:0] coinc, input logic clr_w, input string tag);
        int cn[N];
        int mx;
        cn[0] = c0; cn[1] = c1; cn[2] = c2; cn[3] = c3;
        mx = 0;
        for (int s = 0; s < N; s++) if (cn[s] > mx) mx = cn[s];
        for (int c = 0; c < mx; c++) begin
            logic [N-1:0] m;
            for (int s = 0; s < N; s++) m[s] = (c < cn[s]);
            step(m, 1'b0, 1'b0, "R4 events-only R2");
        end
        step(coinc, 1'b1, clr_w, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) begin
            pre[s] = 10; lo[s] = 3; hi[s] = 7; mcnt[s] = 10; merr[s] = 1'b0;
        end
        rst_n = 1'b0; evt = '0; win = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < N; s++) check(src_err[s] == 1'b0, "R1 reset flag", src_err[s], 0);
        check(any_err == 1'b0, "R1 reset combined", any_err, 0);
        // Counter holds the preset after reset: 10 > 7 fails at once.
        step('0, 1'b1, 1'b0, "R1 preset judged R10");
        step('0, 1'b0, 1'b1, "R8 clear");

        // Sweep event counts across and beyond the preset on all sources.
        for (int k = 0; k < 14; k++) begin
            logic [N-1:0] co;
            co = (k % 4 == 3) ? k[3:0] : '0;
            window(k % 14, (k + 3) % 14, (k + 6) % 14, (k + 9) % 14, co,
                   (k % 5 == 2), (co != 0) ? "R7 coincident R5" : "R5 limits R3 R6 R10");
            if (k % 3 != 0) step('0, 1'b0, 1'b1, "R8 clear");
            else step('0, 1'b0, 1'b0, "R8 sticky hold");
        end

        // Exact boundaries: 3 and 7 events pass, 2 and 8 fail.
        step('0, 1'b0, 1'b1, "R8 clear");
        window(3, 7, 2, 8, '0, 1'b0, "R5 inclusive bounds");
        step('0, 1'b0, 1'b1, "R8 clear");

        // Coincident event lands exactly on a limit only if counted into the new window.
        window(0, 0, 0, 0, 4'b1111, 1'b0, "R7 strobe with events");
        step('0, 1'b0, 1'b1, "R8 clear");
        window(2, 6, 7, 1, '0, 1'b0, "R7 next window R6");
        step('0, 1'b0, 1'b1, "R8 clear");

        // Set wins over clear at the same edge.
        window(0, 0, 0, 0, '0, 1'b1, "R8 set over clear");
        step('0, 1'b0, 1'b1, "R8 clear");

        // Saturation config: a wrapped counter would exceed the upper limit.
        pre[0] = 5; lo[0] = 0; hi[0] = 5;
        pre[1] = 20; lo[1] = 10; hi[1] = 15;
        pre[2] = 0; lo[2] = 0; hi[2] = 0;
        pre[3] = 255; lo[3] = 250; hi[3] = 255;
        step('0, 1'b1, 1'b0, "R6 reload new presets");
        step('0, 1'b0, 1'b1, "R8 clear");
        for (int k = 0; k < 12; k++) begin
            window(k, k + 4, k, k, '0, 1'b0, "R3 saturation R5");
            step('0, 1'b0, 1'b1, "R8 clear");
        end
        window(0, 0, 0, 0, 4'b0101, 1'b0, "R7 zero preset coincident");
        window(9, 0, 3, 5, '0, 1'b0, "R3 R7 after coincident");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule